// File: doc/BRIEF.md
# Conversion Engine Register and Threshold Block

This block is the register front end of a single analog-to-digital conversion engine with up to sixteen channels. A host reaches it over a simple 32-bit register bus that accepts aligned 16-bit and 32-bit accesses within a 256-byte window. It holds the engine's control, clock, detect, interrupt, compensation and interrupt-source registers, one sample word for each pair of channels, and a bound word and a hysteresis word for each channel.

No real conversion happens here. Each read of a sample word returns the stored pair and then advances both samples by fixed unequal steps, standing in for fresh conversions. After the step, both new samples are compared with their channels' limits. A sample outside its window latches an interrupt bit for that pair, and the interrupt output is the OR of the low eight interrupt bits. A channel-count parameter of 8 or 16 removes the upper register banks.

Top module: `adc_eng_regs`

## Requirements
- R1: After reset, every register reads zero except detect control (word offset 0x08) and clock control (0x0C), which read 0x0000000F, and `irq` and `rdValid` are low.
- R2: A read request gives `rdValid` high with `rdData` exactly one cycle later. Writes and idle cycles leave `rdValid` low.
- R3: The sample word for pair n is at 0x10+4n, with the even channel in bits [9:0] and the odd channel in bits [25:16]. A read returns the stored word and then stores low=(low+5) mod 1024 and high=(high+7) mod 1024.
- R4: After that step, if the even sample falls outside bound word 2n, or the odd sample falls outside bound word 2n+1, bit n of interrupt control (0x04) is set. A channel is outside when it is below the limit in bits [9:0] or above the limit in bits [25:16]. Bound word k is at 0x30+4k. A sample inside its limits sets no bit.
- R5: `irq` is high exactly while any of interrupt control bits [7:0] is set. It can only rise one cycle after a bus access.
- R6: A 16-bit access with address bit 1 set reaches the upper half of the word. A read returns that half in `rdData[15:0]`, and a write places `busWdata[15:0]` there and leaves the lower half unchanged. A 16-bit read with bit 1 clear returns the lower half.
- R7: A write to engine control (0x00) stores bit 8 equal to written bit 0 and stores bit 5 as 0. All other bits are kept.
- R8: Write masks. Sample and bound words keep bits [25:16] and [9:0]. Hysteresis words (0x70+4k) also keep bit 31. Interrupt source (0xC0) keeps bits [15:0]. Compensation/trim (0xC4) keeps bits [3:0].
- R9: With `NUM_CH`=8, sample words for pairs 4–7 and the bound and hysteresis words for channels 8–15 ignore writes and read zero.
- R10: Unmapped offsets, odd addresses and 32-bit accesses with address bit 1 set read zero and discard write data.
- R11: Writing interrupt control stores the written value. Clearing bits [7:0] drops `irq` on the next cycle, and `irq` does not change in a cycle with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busHalf | input | 1 | 1 = 16-bit access, 0 = 32-bit |
| busAddr | input | 8 | Byte address within the window |
| busWdata | input | 32 | Write data (16-bit writes use bits [15:0]) |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the mod-1024 wrap of the sample step. A design that carried into the neighbouring field, or that returned the post-step value, would read back a wrong word. It drives each channel of a pair out of its window in turn. A design that compared pre-step values, swapped the even and odd bound words, or set the wrong interrupt bit would then show the wrong `irq` level or interrupt control value. Half-word accesses, engine-control bit forcing, masks, misaligned and unmapped offsets are all read back through the bus. A second instance with eight channels shows whether the disabled banks stay silent instead of storing data.

// File: rtl/adc_eng_pkg.sv
package adc_eng_pkg;
  localparam int SAMPLE_W = 10;
  localparam logic [SAMPLE_W-1:0] LO_STEP = 10'd5;
  localparam logic [SAMPLE_W-1:0] HI_STEP = 10'd7;

  localparam logic [31:0] PAIR_MASK = 32'h03FF_03FF;
  localparam logic [31:0] HYS_MASK  = 32'h83FF_03FF;
  localparam logic [31:0] SRC_MASK  = 32'h0000_FFFF;
  localparam logic [31:0] TRIM_MASK = 32'h0000_000F;
  localparam logic [31:0] DET_RST   = 32'h0000_000F;
  localparam logic [31:0] CLK_RST   = 32'h0000_000F;

  localparam int BIT_ENABLE   = 0;
  localparam int BIT_AUTOCOMP = 5;
  localparam int BIT_READY    = 8;

  typedef enum logic [3:0] {
    RK_NONE, RK_ENG, RK_INT, RK_DET, RK_CLK,
    RK_DATA, RK_BND, RK_HYS, RK_SRC, RK_TRIM
  } regKind_t;

  typedef struct packed {
    logic     wr;
    logic     rd;
    regKind_t kind;
    logic [3:0] idx;
    logic     halfAcc;
    logic     upperHalf;
  } busStrobe_t;
endpackage

// File: rtl/adc_eng_decode.sv
module adc_eng_decode
  import adc_eng_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic       busSel,
  input  logic       busWrite,
  input  logic       busHalf,
  input  logic [7:0] busAddr,
  output busStrobe_t strobe
);
  localparam int NPAIR = NUM_CH / 2;

  logic [5:0] word;
  logic       aligned;
  regKind_t   kind;
  logic [3:0] idx;

  always_comb begin
    word    = busAddr[7:2];
    aligned = !busAddr[0] && (busHalf || !busAddr[1]);
    kind    = RK_NONE;
    idx     = '0;
    if (word == 6'd0)      kind = RK_ENG;
    else if (word == 6'd1) kind = RK_INT;
    else if (word == 6'd2) kind = RK_DET;
    else if (word == 6'd3) kind = RK_CLK;
    else if (int'(word) >= 4 && int'(word) < 4 + NPAIR) begin
      kind = RK_DATA;
      idx  = word[3:0] - 4'd4;
    end else if (int'(word) >= 12 && int'(word) < 12 + NUM_CH) begin
      kind = RK_BND;
      idx  = word[3:0] - 4'd12;
    end else if (int'(word) >= 28 && int'(word) < 28 + NUM_CH) begin
      kind = RK_HYS;
      idx  = word[3:0] - 4'd12;
    end else if (word == 6'd48) kind = RK_SRC;
    else if (word == 6'd49)     kind = RK_TRIM;
    if (!aligned) kind = RK_NONE;

    strobe.wr        = busSel && busWrite;
    strobe.rd        = busSel && !busWrite;
    strobe.kind      = kind;
    strobe.idx       = idx;
    strobe.halfAcc   = busHalf;
    strobe.upperHalf = busHalf && busAddr[1];
  end
endmodule

// File: rtl/adc_eng_sampler.sv
module adc_eng_sampler
  import adc_eng_pkg::*;
(
  input  logic [SAMPLE_W-1:0] curLo,
  input  logic [SAMPLE_W-1:0] curHi,
  input  logic [SAMPLE_W-1:0] evenMin,
  input  logic [SAMPLE_W-1:0] evenMax,
  input  logic [SAMPLE_W-1:0] oddMin,
  input  logic [SAMPLE_W-1:0] oddMax,
  output logic [SAMPLE_W-1:0] nextLo,
  output logic [SAMPLE_W-1:0] nextHi,
  output logic                outOfRange
);
  always_comb begin
    nextLo     = curLo + LO_STEP;
    nextHi     = curHi + HI_STEP;
    outOfRange = (nextLo < evenMin) || (nextLo > evenMax) ||
                 (nextHi < oddMin)  || (nextHi > oddMax);
  end
endmodule

// File: rtl/adc_eng_regfile.sv
module adc_eng_regfile
  import adc_eng_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrobe_t  strobe,
  input  logic [31:0] busWdata,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        irq
);
  localparam int NPAIR = NUM_CH / 2;
  localparam int PW    = $clog2(NPAIR);
  localparam int CW    = $clog2(NUM_CH);

  logic [31:0] engCtl, intCtl, detCtl, clkCtl, intSrc, trimReg;
  logic [31:0] dataQ [NPAIR];
  logic [31:0] bndQ  [NUM_CH];
  logic [31:0] hysQ  [NUM_CH];

  logic [PW-1:0] pIdx;
  logic [CW-1:0] cIdx;
  logic [31:0]   curVal, merged, wrVal, evenBnd, oddBnd;
  logic [SAMPLE_W-1:0] nextLo, nextHi;
  logic          outOfRange;

  assign pIdx = strobe.idx[PW-1:0];
  assign cIdx = strobe.idx[CW-1:0];

  always_comb begin
    case (strobe.kind)
      RK_ENG:  curVal = engCtl;
      RK_INT:  curVal = intCtl;
      RK_DET:  curVal = detCtl;
      RK_CLK:  curVal = clkCtl;
      RK_DATA: curVal = dataQ[pIdx];
      RK_BND:  curVal = bndQ[cIdx];
      RK_HYS:  curVal = hysQ[cIdx];
      RK_SRC:  curVal = intSrc;
      RK_TRIM: curVal = trimReg;
      default: curVal = '0;
    endcase
  end

  always_comb begin
    if (!strobe.halfAcc)       merged = busWdata;
    else if (strobe.upperHalf) merged = {busWdata[15:0], curVal[15:0]};
    else                       merged = {curVal[31:16], busWdata[15:0]};
    wrVal = merged;
    case (strobe.kind)
      RK_ENG: begin
        wrVal[BIT_READY]    = merged[BIT_ENABLE];
        wrVal[BIT_AUTOCOMP] = 1'b0;
      end
      RK_DATA, RK_BND: wrVal = merged & PAIR_MASK;
      RK_HYS:          wrVal = merged & HYS_MASK;
      RK_SRC:          wrVal = merged & SRC_MASK;
      RK_TRIM:         wrVal = merged & TRIM_MASK;
      default:         wrVal = merged;
    endcase
  end

  assign evenBnd = bndQ[{pIdx, 1'b0}];
  assign oddBnd  = bndQ[{pIdx, 1'b1}];

  adc_eng_sampler u_sampler (
    .curLo      (dataQ[pIdx][9:0]),
    .curHi      (dataQ[pIdx][25:16]),
    .evenMin    (evenBnd[9:0]),
    .evenMax    (evenBnd[25:16]),
    .oddMin     (oddBnd[9:0]),
    .oddMax     (oddBnd[25:16]),
    .nextLo     (nextLo),
    .nextHi     (nextHi),
    .outOfRange (outOfRange)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engCtl  <= '0;
      intCtl  <= '0;
      detCtl  <= DET_RST;
      clkCtl  <= CLK_RST;
      intSrc  <= '0;
      trimReg <= '0;
      for (int i = 0; i < NPAIR; i++)  dataQ[i] <= '0;
      for (int i = 0; i < NUM_CH; i++) bndQ[i]  <= '0;
      for (int i = 0; i < NUM_CH; i++) hysQ[i]  <= '0;
    end else if (strobe.wr) begin
      case (strobe.kind)
        RK_ENG:  engCtl       <= wrVal;
        RK_INT:  intCtl       <= wrVal;
        RK_DET:  detCtl       <= wrVal;
        RK_CLK:  clkCtl       <= wrVal;
        RK_DATA: dataQ[pIdx]  <= wrVal;
        RK_BND:  bndQ[cIdx]   <= wrVal;
        RK_HYS:  hysQ[cIdx]   <= wrVal;
        RK_SRC:  intSrc       <= wrVal;
        RK_TRIM: trimReg      <= wrVal;
        default: ;
      endcase
    end else if (strobe.rd && strobe.kind == RK_DATA) begin
      dataQ[pIdx] <= {6'd0, nextHi, 6'd0, nextLo};
      if (outOfRange) intCtl[pIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.rd;
      if (strobe.rd) begin
        if (strobe.upperHalf)    rdData <= {16'd0, curVal[31:16]};
        else if (strobe.halfAcc) rdData <= {16'd0, curVal[15:0]};
        else                     rdData <= curVal;
      end
    end
  end

  assign irq = |intCtl[7:0];
endmodule

// File: rtl/adc_eng_regs.sv
module adc_eng_regs
  import adc_eng_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic        busHalf,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic        irq
);
  busStrobe_t strobe;

  adc_eng_decode #(.NUM_CH(NUM_CH)) u_decode (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busHalf  (busHalf),
    .busAddr  (busAddr),
    .strobe   (strobe)
  );

  adc_eng_regfile #(.NUM_CH(NUM_CH)) u_regfile (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .irq      (irq)
  );
endmodule

// File: rtl/adc_eng_regs_chk.sv
module adc_eng_regs_chk (
  input logic clk,
  input logic rstN,
  input logic busSel,
  input logic busWrite,
  input logic rdValid,
  input logic irq
);
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite |=> rdValid);                                   // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> !rdValid);                               // R2
  AST_IRQ_RISE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busSel));                                      // R5
  AST_IRQ_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> $stable(irq));                                          // R11
  AST_IRQ_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busSel && busWrite));                          // R11
endmodule

bind adc_eng_regs adc_eng_regs_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .rdValid  (rdValid),
  .irq      (irq)
);

// File: tb/sim_adc_eng_regs.sv
module sim_adc_eng_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busHalf = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        rdValid, irq, rdValid8, irq8;
  logic [31:0] rdData, rdData8;

  int total = 0;
  int fails = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  adc_eng_regs u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busHalf(busHalf), .busAddr(busAddr), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData), .irq(irq)
  );

  adc_eng_regs #(.NUM_CH(8)) u1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busHalf(busHalf), .busAddr(busAddr), .busWdata(busWdata),
    .rdValid(rdValid8), .rdData(rdData8), .irq(irq8)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every valid read pops one expected word.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        chk("R2 unexpected rdValid", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(t, rdData, e);
      end
    end
  end

  task automatic busWr(input logic [7:0] a, input logic [31:0] d, input logic h);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busHalf = h;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busHalf = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, input logic h, input logic [31:0] exp,
                       input string tag);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busHalf = h;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busSel = 1'b0; busHalf = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 rdValid after reset", {31'd0, rdValid}, 32'd0);
    busRd(8'h00, 1'b0, 32'h0000_0000, "R1 engine control reset");
    busRd(8'h04, 1'b0, 32'h0000_0000, "R1 interrupt control reset");
    busRd(8'h08, 1'b0, 32'h0000_000F, "R1 detect control reset");
    busRd(8'h0C, 1'b0, 32'h0000_000F, "R1 clock control reset");
    busWr(8'h00, 32'h0, 1'b0);
    chk("R2 no valid after write", {31'd0, rdValid}, 32'd0);

    // R3 sample stepping, pair 0 with full-range bounds
    busWr(8'h30, 32'h03FF_0000, 1'b0);
    busWr(8'h34, 32'h03FF_0000, 1'b0);
    busWr(8'h10, 32'h0064_0032, 1'b0);
    busRd(8'h10, 1'b0, 32'h0064_0032, "R3 first read returns stored");
    busRd(8'h10, 1'b0, 32'h006B_0037, "R3 stepped by 5 and 7");
    chk("R4 in-range read leaves irq low", {31'd0, irq}, 32'd0);
    busWr(8'h10, 32'hFFFF_FFFF, 1'b0);
    busRd(8'h10, 1'b0, 32'h03FF_03FF, "R8 sample write mask");
    busRd(8'h10, 1'b0, 32'h0006_0004, "R3 mod 1024 wrap");

    // R6 half-word reads on the sample word
    busRd(8'h12, 1'b1, 32'h0000_000D, "R6 upper half read");
    busRd(8'h10, 1'b1, 32'h0000_000E, "R6 lower half read");

    // R4 even channel below its limit
    busWr(8'h38, 32'h0014_000A, 1'b0);
    busWr(8'h3C, 32'h03FF_0000, 1'b0);
    busWr(8'h14, 32'h0000_0002, 1'b0);
    busRd(8'h14, 1'b0, 32'h0000_0002, "R3 pair1 read");
    chk("R5 irq after even breach", {31'd0, irq}, 32'd1);
    busRd(8'h04, 1'b0, 32'h0000_0002, "R4 pair1 interrupt bit");
    busWr(8'h04, 32'h0, 1'b0);
    chk("R11 irq cleared by write", {31'd0, irq}, 32'd0);

    // R4 odd channel above its limit
    busWr(8'h40, 32'h03FF_0000, 1'b0);
    busWr(8'h44, 32'h0005_0000, 1'b0);
    busWr(8'h18, 32'h0, 1'b0);
    busRd(8'h18, 1'b0, 32'h0000_0000, "R3 pair2 read");
    chk("R5 irq after odd breach", {31'd0, irq}, 32'd1);
    busRd(8'h04, 1'b0, 32'h0000_0004, "R4 pair2 interrupt bit");
    repeat (3) @(negedge clk);
    chk("R11 irq holds while idle", {31'd0, irq}, 32'd1);

    // R6 half write
    busWr(8'h0E, 32'h0000_ABCD, 1'b1);
    busRd(8'h0C, 1'b0, 32'hABCD_000F, "R6 upper half write");

    // R7 engine control forcing
    busWr(8'h00, 32'h00FF_0021, 1'b0);
    busRd(8'h00, 1'b0, 32'h00FF_0101, "R7 ready follows enable, autocomp cleared");
    busWr(8'h00, 32'h0000_012E, 1'b0);
    busRd(8'h00, 1'b0, 32'h0000_000E, "R7 ready cleared with enable");

    // R8 masks
    busWr(8'h70, 32'hFFFF_FFFF, 1'b0);
    busRd(8'h70, 1'b0, 32'h83FF_03FF, "R8 hysteresis mask");
    busWr(8'hC0, 32'hFFFF_FFFF, 1'b0);
    busRd(8'hC0, 1'b0, 32'h0000_FFFF, "R8 interrupt source mask");
    busWr(8'hC4, 32'hFFFF_FFFF, 1'b0);
    busRd(8'hC4, 1'b0, 32'h0000_000F, "R8 trim mask");
    busWr(8'h58, 32'hFFFF_FFFF, 1'b0);
    busRd(8'h58, 1'b0, 32'h03FF_03FF, "R8 bound mask");

    // R10 unmapped and misaligned
    busWr(8'hB0, 32'h1234_5678, 1'b0);
    busRd(8'hB0, 1'b0, 32'h0, "R10 unmapped reads zero");
    busRd(8'h05, 1'b0, 32'h0, "R10 odd address reads zero");
    busRd(8'h06, 1'b0, 32'h0, "R10 word access with bit1 reads zero");
    busWr(8'h05, 32'hFFFF_FFFF, 1'b0);
    busRd(8'h04, 1'b0, 32'h0000_0004, "R10 misaligned write discarded");

    // R9 eight-channel instance
    busWr(8'h20, 32'h0001_0001, 1'b0);
    busRd(8'h20, 1'b0, 32'h0001_0001, "R9 pair4 on 16-ch");
    chk("R9 pair4 on 8-ch reads zero", rdData8, 32'h0);
    busWr(8'h50, 32'h0022_0011, 1'b0);
    busRd(8'h50, 1'b0, 32'h0022_0011, "R9 bound8 on 16-ch");
    chk("R9 bound8 on 8-ch reads zero", rdData8, 32'h0);
    busWr(8'h90, 32'h8000_0005, 1'b0);
    busRd(8'h90, 1'b0, 32'h8000_0005, "R9 hyst8 on 16-ch");
    chk("R9 hyst8 on 8-ch reads zero", rdData8, 32'h0);
    busWr(8'h4C, 32'h0005_0003, 1'b0);
    busRd(8'h4C, 1'b0, 32'h0005_0003, "R9 bound7 on 16-ch");
    chk("R9 bound7 on 8-ch kept", rdData8, 32'h0005_0003);

    repeat (3) @(negedge clk);
    chk("R2 every read answered", expQ.size(), 32'd0);
    finishRun();
  end
endmodule